// File: doc/BRIEF.md
# Back-Porch Clamp Window Generator

This block produces, once per video line, the timing window during which an analog front end restores its black level. The window begins a programmable number of pixel clocks after the end of horizontal sync and lasts a programmable number of pixel clocks. Placing the window after the trailing edge puts it on the back porch, which always carries a clean black reference, and keeps it off the sync tip.

The block also reports a clamp target code for each colour channel. RGB inputs normally clamp to the bottom code. Colour-difference inputs have their reference at mid-range, so they clamp to the midscale code. A per-channel bit chooses between the two.

While the sync source is unreliable, a coast input suppresses the window. A placement of 8 and a duration of 20 pixel clocks are reasonable starting values.

Top module: `clamp_window_gen`

## Requirements
- R1: After a synchronous reset with sync held inactive, `clamp_o` is 0 and stays 0 until a trailing sync edge is seen.
- R2: When `sync_pol` is 1, sync is active high and its falling edge is the trailing edge. When `sync_pol` is 0, sync is active low and its rising edge is the trailing edge. The leading edge never starts a window.
- R3: Let E be the first rising clock edge that samples sync inactive after it was active. `clamp_o` rises on clock edge E+P, where P is `place_i`. If P is 0, `clamp_o` rises on edge E itself.
- R4: Once raised, `clamp_o` stays high for exactly D clock cycles, where D is `dur_i`, with D taken from 1 to 255.
- R5: A trailing edge that arrives with `dur_i` equal to 0 produces no clamp pulse for that line.
- R6: A trailing edge during the placement count or during the clamp pulse ends the current window at once. `clamp_o` falls on edge E of the new trailing edge, unless the new `place_i` is 0. Timing then restarts from the new edge as in R3 and R4.
- R7: While `coast` is 1 on a clock edge, `clamp_o` is 0 after that edge. Any running window is ended, and trailing edges sampled during coast start nothing.
- R8: `target_o[8c+7:8c]` is the clamp code of channel c, for c from 0 to 2. It is 0x80 when `mid_sel_i[c]` is 1 and 0x00 when it is 0.
- R9: `place_i` and `dur_i` are captured on edge E. Changes to them during a window have no effect on that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Horizontal sync |
| sync_pol | input | 1 | Sync active level: 1 means active high |
| place_i | input | 8 | Pixel clocks from the trailing edge to the start of the clamp |
| dur_i | input | 8 | Clamp length in pixel clocks; 0 means no clamp |
| mid_sel_i | input | 3 | Per-channel target select: 1 selects midscale, 0 selects ground |
| coast | input | 1 | Suppresses the window while sync is unreliable |
| clamp_o | output | 1 | Clamp window |
| target_o | output | 24 | Per-channel clamp codes, channel c in bits 8c+7..8c |

## Verification
Some properties are checked on every cycle. Coast always silences the window on the next cycle. A zero duration never produces a pulse. A zero placement starts the clamp on the very next cycle. A nonzero placement always drops the window after a trailing edge. The remaining clamp count never reaches the captured duration.

Other behaviour needs a full line of stimulus and can only be shown by the bench's scenarios. This covers the exact start cycle and width of each pulse for both sync polarities. It also covers the cut-short pulse when sync retriggers mid-clamp, the missing pulse when it retriggers during placement, and indifference to settings changed mid-window. The bench also sweeps all select patterns.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
    localparam int CNT_W  = 8;
    localparam int CODE_W = 8;
    localparam int NCH    = 3;

    typedef enum logic [1:0] {
        CW_IDLE  = 2'd0,
        CW_PLACE = 2'd1,
        CW_HOLD  = 2'd2
    } cw_state_e;

    typedef struct packed {
        cw_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] dur;
    } cw_ctx_t;

    localparam logic [CODE_W-1:0] CODE_GND = '0;
    localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};

    function automatic logic [CODE_W-1:0] clamp_code(input logic mid);
        return mid ? CODE_MID : CODE_GND;
    endfunction
endpackage

// File: rtl/sync_trail_det.sv
module sync_trail_det (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic sync_pol,
    output logic trail
);
    logic s_q;
    logic act_now;
    logic act_q;

    always_ff @(posedge clk) begin
        if (rst) s_q <= sync_in;
        else     s_q <= sync_in;
    end

    assign act_now = (sync_in == sync_pol);
    assign act_q   = (s_q == sync_pol);
    assign trail   = act_q & ~act_now & ~rst;
endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
    import clamp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trail,
    input  logic             coast,
    input  logic [CNT_W-1:0] place,
    input  logic [CNT_W-1:0] dur,
    output logic             win
);
    cw_ctx_t ctx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '{st: CW_IDLE, cnt: '0, dur: '0};
        end else if (coast) begin
            ctx.st  <= CW_IDLE;
            ctx.cnt <= '0;
        end else if (trail) begin
            ctx.dur <= dur;
            if (dur == '0) begin
                ctx.st  <= CW_IDLE;
                ctx.cnt <= '0;
            end else if (place == '0) begin
                ctx.st  <= CW_HOLD;
                ctx.cnt <= dur - 1'b1;
            end else begin
                ctx.st  <= CW_PLACE;
                ctx.cnt <= place - 1'b1;
            end
        end else begin
            case (ctx.st)
                CW_PLACE: begin
                    if (ctx.cnt == '0) begin
                        ctx.st  <= CW_HOLD;
                        ctx.cnt <= ctx.dur - 1'b1;
                    end else begin
                        ctx.cnt <= ctx.cnt - 1'b1;
                    end
                end
                CW_HOLD: begin
                    if (ctx.cnt == '0) ctx.st <= CW_IDLE;
                    else               ctx.cnt <= ctx.cnt - 1'b1;
                end
                default: ctx.st <= CW_IDLE;
            endcase
        end
    end

    assign win = (ctx.st == CW_HOLD);

    // R7
    coast_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        coast |=> !win);

    // R5
    zero_dur_chk: assert property (@(posedge clk) disable iff (rst)
        (trail && !coast && dur == '0) |=> !win);

    // R3
    imm_start_chk: assert property (@(posedge clk) disable iff (rst)
        (trail && !coast && dur != '0 && place == '0) |=> win);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (trail && !coast && place != '0) |=> !win);

    // R4
    hold_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx.st == CW_HOLD) |-> (ctx.cnt < ctx.dur));
endmodule

// File: rtl/target_sel.sv
module target_sel
    import clamp_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic [N-1:0]        mid_sel,
    output logic [N*CODE_W-1:0] target
);
    for (genvar c = 0; c < N; c++) begin : g_ch
        assign target[c*CODE_W +: CODE_W] = clamp_code(mid_sel[c]);
    end
endmodule

// File: rtl/clamp_window_gen.sv
module clamp_window_gen
    import clamp_pkg::*;
#(
    parameter int N_CH = NCH,
    localparam int TW  = N_CH * CODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic             sync_pol,
    input  logic [CNT_W-1:0] place_i,
    input  logic [CNT_W-1:0] dur_i,
    input  logic [N_CH-1:0]  mid_sel_i,
    input  logic             coast,
    output logic             clamp_o,
    output logic [TW-1:0]    target_o
);
    logic trail;

    sync_trail_det u_det (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_in),
        .sync_pol (sync_pol),
        .trail    (trail)
    );

    clamp_timer u_tmr (
        .clk   (clk),
        .rst   (rst),
        .trail (trail),
        .coast (coast),
        .place (place_i),
        .dur   (dur_i),
        .win   (clamp_o)
    );

    target_sel #(.N(N_CH)) u_tgt (
        .mid_sel (mid_sel_i),
        .target  (target_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !clamp_o);
endmodule

// File: tb/sim_clamp_window_gen.sv
module sim_clamp_window_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_in = 1'b0;
    logic       sync_pol = 1'b1;
    logic [7:0] place_i = 8'd8;
    logic [7:0] dur_i = 8'd20;
    logic [2:0] mid_sel_i = 3'b000;
    logic       coast = 1'b0;
    logic       clamp_o;
    logic [23:0] target_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string ctx_req = "R1";

    int    q_start[$];
    int    q_len[$];
    string q_req[$];

    clamp_window_gen u0 (
        .clk(clk), .rst(rst), .sync_in(sync_in), .sync_pol(sync_pol),
        .place_i(place_i), .dur_i(dur_i), .mid_sel_i(mid_sel_i),
        .coast(coast), .clamp_o(clamp_o), .target_o(target_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int s, input int l, input string req);
        q_start.push_back(s);
        q_len.push_back(l);
        q_req.push_back(req);
    endtask

    // Scoreboard monitor: measure each clamp pulse and compare with the queue
    bit prev = 1'b0;
    int st = 0;
    always @(negedge clk) begin
        if (rst) begin
            prev <= 1'b0;
        end else begin
            if (clamp_o && !prev) st = cyc;
            if (!clamp_o && prev) begin
                if (q_start.size() == 0) begin
                    chk(1'b0, ctx_req, st, -1);
                end else begin
                    int es, el;
                    string r;
                    es = q_start.pop_front();
                    el = q_len.pop_front();
                    r  = q_req.pop_front();
                    chk(st == es, r, st, es);
                    chk(cyc - st == el, r, cyc - st, el);
                end
            end
            prev <= clamp_o;
        end
    end

    function automatic logic act_lvl();
        return sync_pol;
    endfunction

    // One sync line: active for hi cycles, trailing edge, then gap cycles
    task automatic line(input int p, input int d, input int hi, input int gap,
                        input string req, input bit expect_pulse);
        int n;
        ctx_req = req;
        sync_in = act_lvl();
        tick(hi);
        place_i = p[7:0];
        dur_i   = d[7:0];
        sync_in = ~act_lvl();
        n = cyc;
        if (expect_pulse && d > 0) push(n + 1 + p, d, req);
        tick(gap);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(clamp_o == 1'b0, "R1", clamp_o, 0);
        tick(10);
        chk(clamp_o == 1'b0, "R1", clamp_o, 0);

        // R3 R4 main timing, active-high sync
        line(8, 20, 6, 40, "R3", 1);
        line(0, 1, 3, 10, "R3", 1);
        line(3, 255, 5, 270, "R4", 1);
        line(255, 2, 2, 265, "R4", 1);
        line(1, 7, 1, 15, "R4", 1);

        // R5 zero duration
        line(4, 0, 5, 30, "R5", 1);
        chk(q_start.size() == 0, "R5", q_start.size(), 0);

        // R2 active-low sync: rising edge is trailing
        sync_pol = 1'b0;
        tick(3);
        chk(clamp_o == 1'b0, "R2", clamp_o, 0);
        line(5, 9, 12, 25, "R2", 1);
        line(0, 4, 4, 12, "R2", 1);
        sync_pol = 1'b1;
        tick(3);

        // R6 retrigger during placement: only the second window
        begin
            ctx_req = "R6";
            sync_in = 1'b1; tick(3);
            place_i = 10; dur_i = 5;
            sync_in = 1'b0; tick(4);
            sync_in = 1'b1; tick(2);
            sync_in = 1'b0;
            push(cyc + 1 + 10, 5, "R6");
            tick(30);
        end
        // R6 retrigger during the clamp: truncated then fresh window
        begin
            int n1, n2;
            sync_in = 1'b1; tick(3);
            place_i = 2; dur_i = 20;
            sync_in = 1'b0; n1 = cyc;
            tick(8);
            sync_in = 1'b1; tick(2);
            sync_in = 1'b0; n2 = cyc;
            push(n1 + 3, (n2 + 1) - (n1 + 3), "R6");
            push(n2 + 3, 20, "R6");
            tick(40);
        end

        // R7 trailing edge during coast starts nothing
        coast = 1'b1;
        line(2, 6, 4, 5, "R7", 0);
        coast = 1'b0;
        tick(20);
        chk(q_start.size() == 0, "R7", q_start.size(), 0);
        // R7 coast cuts a running clamp
        begin
            int n, m;
            sync_in = 1'b1; tick(3);
            place_i = 1; dur_i = 20;
            sync_in = 1'b0; n = cyc;
            tick(6);
            coast = 1'b1; m = cyc;
            push(n + 2, (m + 1) - (n + 2), "R7");
            tick(3);
            chk(clamp_o == 1'b0, "R7", clamp_o, 0);
            coast = 1'b0;
            tick(30);
        end

        // R9 settings changed mid-window are ignored
        begin
            int n;
            ctx_req = "R9";
            sync_in = 1'b1; tick(3);
            place_i = 4; dur_i = 6;
            sync_in = 1'b0; n = cyc;
            push(n + 5, 6, "R9");
            tick(1);
            place_i = 50; dur_i = 1;
            tick(30);
        end

        // R8 target codes for every select pattern
        for (int s = 0; s < 8; s++) begin
            logic [23:0] exp;
            mid_sel_i = s[2:0];
            for (int c = 0; c < 3; c++) exp[c*8 +: 8] = s[c] ? 8'h80 : 8'h00;
            #1;
            chk(target_o == exp, "R8", target_o, exp);
            tick(1);
        end

        tick(5);
        chk(q_start.size() == 0, "R3", q_start.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule